// File: doc/BRIEF.md
# ISA Register Access Bridge

This block is an I/O slave on an ISA-style bus that gives system software access to a small bank of 16-bit internal registers. It qualifies each bus command against a 32-byte I/O window. While the register side is busy it holds the bus with the channel-ready line pulled low, and it keeps the cycle open until the host drops its strobe. A plain 8-bit host reads a register one byte at a time, and the bridge moves the requested byte onto the low data lane. To write a register, the host writes the even byte and then the odd byte. The bridge keeps the even byte in a holding register and issues one 16-bit register write when the odd byte arrives. When 16-bit I/O cycles are enabled, even-address register accesses move a whole word and assert the 16-bit-cycle indication.

The lower 16 bytes of the window are a read-only station-address store. It is copied from a strap input while reset is held, and bus writes cannot change it. One further address in the window is a read-to-reset location: reading it produces a one-cycle internal controller reset pulse.

The register side uses a valid/ready request channel and a separate response strobe. Once `reg_req_valid` is asserted, it stays high and `reg_req_write`, `reg_req_idx`, `reg_be` and `reg_wdata` stay constant until a cycle in which `reg_req_ready` is high. A write completes at that acceptance. After a read is accepted, the bridge waits any number of cycles for a one-cycle `reg_rsp_valid` carrying `reg_rdata`. The response may not arrive in the cycle of acceptance itself. The register side can apply back-pressure indefinitely, and the ISA cycle stays stretched for as long as it does.

Top module: `isa_reg_bridge`

## Requirements
- R1: A cycle is taken only when `aen` is low, `bus_addr` lies in the 32-byte window at `BASE`, the offset is a station-address, register or reset location, and `ior_n` or `iow_n` is low. Otherwise no register request is made and `sd_oe_lo` stays low.
- R2: `chrdy_low` is high while a register request or read response is outstanding, and low whenever read data is being driven.
- R3: Read data stays driven, and the cycle stays open, until both `ior_n` and `iow_n` are high. `sd_oe_lo` falls in the cycle after the strobe is released.
- R4: A read at offsets 0 to 15 returns byte k of `sa_init` (bits 8k+7..8k) on `sd_out[7:0]`. A write to these offsets changes nothing and makes no register request.
- R5: Registers sit at offset 16+2i (low byte) and 17+2i (high byte). An 8-bit read of an odd offset returns the register's high byte on `sd_out[7:0]`, and an even offset returns its low byte. `sd_oe_hi` stays low. `reg_be` is 01 for an even byte and 10 for an odd byte.
- R6: An 8-bit write to an even register offset makes no request and only stores the byte. The next odd-offset write issues one write with `reg_wdata` = {odd byte, held byte} and `reg_be` = 11.
- R7: An odd-offset write with no even write since the last odd write uses the holding register's current byte, and `stale_odd` is high while that write request is pending.
- R8: With `wide_en` high, an even-offset register access is a 16-bit cycle. `iocs16_low` is high through the cycle, a write passes `sd_in` whole, and a read drives all 16 bits with `sd_oe_hi` high.
- R9: `iocs16_low` is never high during station-address or reset-address cycles.
- R10: A read at offset `RST_OFF` (24) raises `ctrl_reset` for exactly one cycle. A write there produces no pulse.
- R11: A request holds `reg_req_valid` and its fields stable until accepted, and register read data reaches the bus only after `reg_rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Active-low reset; also loads the station-address store |
| wide_en | input | 1 | Enables 16-bit I/O cycles on even register offsets |
| bus_addr | input | ADDR_W | I/O address |
| aen | input | 1 | Address-enable; high blocks I/O decoding |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| sd_in | input | 16 | Data from the bus |
| sd_out | output | 16 | Data to the bus |
| sd_oe_lo | output | 1 | Drive enable for the low data lane |
| sd_oe_hi | output | 1 | Drive enable for the high data lane |
| chrdy_low | output | 1 | Pulls channel-ready low (wait) |
| iocs16_low | output | 1 | Asserts the 16-bit I/O cycle indication |
| sa_init | input | 128 | Station-address bytes, captured during reset |
| ctrl_reset | output | 1 | One-cycle internal controller reset pulse |
| stale_odd | output | 1 | Pending write was merged with a stale held byte |
| reg_req_valid | output | 1 | Register request valid |
| reg_req_ready | input | 1 | Register request accepted |
| reg_req_write | output | 1 | Request is a write |
| reg_req_idx | output | IDX_W | Register index |
| reg_be | output | 2 | Byte lanes of the request |
| reg_wdata | output | 16 | Write data |
| reg_rsp_valid | input | 1 | Read response strobe |
| reg_rdata | input | 16 | Read response data |

## Verification
Embedded properties check, on every clock, that a pending request holds still under back-pressure, that read data is never driven while the wait line is low, that the drive enable drops only after the strobe was released, that the 16-bit indication appears only on register cycles and always accompanies the high lane, and that the reset pulse lasts one cycle. The bench's scenarios are needed to show the data path: the correct byte for each offset, the even/odd write merge and the stale-byte case, write protection of the station address, the lack of response to unqualified commands, and the difference between reading and writing the reset location.

// File: rtl/isa_bridge_pkg.sv
package isa_bridge_pkg;
  localparam int SA_BYTES = 16;
  localparam int DATA_W   = 16;

  typedef enum logic [1:0] {K_NONE, K_SA, K_REG, K_RST} acc_kind_e;
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RSP, S_DONE} cyc_state_e;
endpackage

// File: rtl/isa_addr_decode.sv
module isa_addr_decode
  import isa_bridge_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int BASE     = 'h300,
  parameter int NUM_REGS = 3,
  parameter int RST_OFF  = 24,
  parameter int IDX_W    = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_e         kind,
  output logic [3:0]        sa_sel,
  output logic [IDX_W-1:0]  reg_idx,
  output logic              odd
);
  localparam int WIN_LSB = 5;
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE);
  localparam logic [5:0] REG_END = 6'(16 + 2 * NUM_REGS);
  localparam logic [4:0] RST_V = 5'(RST_OFF);

  logic [4:0] off;
  logic [4:0] off_rel;
  logic       in_win;

  assign off     = addr[WIN_LSB-1:0];
  assign off_rel = off - 5'd16;
  assign in_win  = (addr[ADDR_W-1:WIN_LSB] == BASE_V[ADDR_W-1:WIN_LSB]);
  assign sa_sel  = off[3:0];
  assign reg_idx = IDX_W'(off_rel >> 1);
  assign odd     = off[0];

  always_comb begin
    kind = K_NONE;
    if (in_win) begin
      if (off == RST_V)                            kind = K_RST;
      else if (!off[4])                            kind = K_SA;
      else if ({1'b0, off} < REG_END)              kind = K_REG;
    end
  end
endmodule

// File: rtl/isa_sa_ram.sv
module isa_sa_ram
  import isa_bridge_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [8*SA_BYTES-1:0] init,
  input  logic [3:0]            sel,
  output logic [7:0]            rd_byte
);
  logic [8*SA_BYTES-1:0] mem_q;

  // Loaded only while reset is held; no bus write path exists.
  always_ff @(posedge clk) begin
    if (!rst_n) mem_q <= init;
  end

  assign rd_byte = mem_q[{sel, 3'b000} +: 8];
endmodule

// File: rtl/isa_byte_merge.sv
module isa_byte_merge
  import isa_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_even,
  input  logic [7:0]        even_byte,
  input  logic              consume,
  output logic [7:0]        held_byte,
  output logic              held_valid,
  input  logic [DATA_W-1:0] rsp_word,
  input  logic              odd_lane,
  input  logic              wide,
  output logic [DATA_W-1:0] lane_word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_byte  <= 8'h00;
      held_valid <= 1'b0;
    end else if (load_even) begin
      held_byte  <= even_byte;
      held_valid <= 1'b1;
    end else if (consume) begin
      held_valid <= 1'b0;
    end
  end

  // Read steering: odd byte moves down to the low lane in 8-bit cycles.
  always_comb begin
    if (wide)          lane_word = rsp_word;
    else if (odd_lane) lane_word = {8'h00, rsp_word[15:8]};
    else               lane_word = {8'h00, rsp_word[7:0]};
  end
endmodule

// File: rtl/isa_reg_bridge.sv
module isa_reg_bridge
  import isa_bridge_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int BASE     = 'h300,
  parameter int NUM_REGS = 3,
  parameter int RST_OFF  = 24,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wide_en,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  aen,
  input  logic                  ior_n,
  input  logic                  iow_n,
  input  logic [DATA_W-1:0]     sd_in,
  output logic [DATA_W-1:0]     sd_out,
  output logic                  sd_oe_lo,
  output logic                  sd_oe_hi,
  output logic                  chrdy_low,
  output logic                  iocs16_low,
  input  logic [8*SA_BYTES-1:0] sa_init,
  output logic                  ctrl_reset,
  output logic                  stale_odd,
  output logic                  reg_req_valid,
  input  logic                  reg_req_ready,
  output logic                  reg_req_write,
  output logic [IDX_W-1:0]      reg_req_idx,
  output logic [1:0]            reg_be,
  output logic [DATA_W-1:0]     reg_wdata,
  input  logic                  reg_rsp_valid,
  input  logic [DATA_W-1:0]     reg_rdata
);
  acc_kind_e        dec_kind;
  logic [3:0]       dec_sa;
  logic [IDX_W-1:0] dec_idx;
  logic             dec_odd;
  logic [7:0]       sa_byte;
  logic [7:0]       held_byte;
  logic             held_valid;
  logic [DATA_W-1:0] lane_word;

  cyc_state_e       st;
  acc_kind_e        cur_kind;
  logic             cur_wr, cur_wide, cur_odd, stale_q, rst_q;
  logic [IDX_W-1:0] cur_idx;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  logic cmd_on, start, is_reg, wide_now, ld_even, take_odd;

  isa_addr_decode #(
    .ADDR_W(ADDR_W), .BASE(BASE), .NUM_REGS(NUM_REGS),
    .RST_OFF(RST_OFF), .IDX_W(IDX_W)
  ) u_dec (
    .addr(bus_addr), .kind(dec_kind), .sa_sel(dec_sa),
    .reg_idx(dec_idx), .odd(dec_odd)
  );

  isa_sa_ram u_sa (
    .clk(clk), .rst_n(rst_n), .init(sa_init), .sel(dec_sa), .rd_byte(sa_byte)
  );

  assign cmd_on   = !aen && (!ior_n || !iow_n);
  assign start    = (st == S_IDLE) && cmd_on && (dec_kind != K_NONE);
  assign is_reg   = (dec_kind == K_REG);
  assign wide_now = wide_en && is_reg && !dec_odd;
  assign ld_even  = start && is_reg && !iow_n && !wide_now && !dec_odd;
  assign take_odd = start && is_reg && !iow_n && !wide_now && dec_odd;

  isa_byte_merge u_merge (
    .clk(clk), .rst_n(rst_n),
    .load_even(ld_even), .even_byte(sd_in[7:0]), .consume(take_odd),
    .held_byte(held_byte), .held_valid(held_valid),
    .rsp_word(reg_rdata), .odd_lane(cur_odd), .wide(cur_wide),
    .lane_word(lane_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cur_kind <= K_NONE;
      cur_wr   <= 1'b0;
      cur_wide <= 1'b0;
      cur_odd  <= 1'b0;
      cur_idx  <= '0;
      stale_q  <= 1'b0;
      rst_q    <= 1'b0;
      wdata_q  <= '0;
      rdata_q  <= '0;
    end else begin
      rst_q <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          cur_kind <= dec_kind;
          cur_wr   <= !iow_n;
          cur_wide <= wide_now;
          cur_odd  <= dec_odd;
          cur_idx  <= dec_idx;
          stale_q  <= 1'b0;
          rdata_q  <= '0;
          unique case (dec_kind)
            K_SA: begin
              rdata_q <= {8'h00, sa_byte};
              st      <= S_DONE;
            end
            K_RST: begin
              rst_q <= iow_n;
              st    <= S_DONE;
            end
            default: begin
              if (!iow_n) begin
                if (wide_now) begin
                  wdata_q <= sd_in;
                  st      <= S_REQ;
                end else if (dec_odd) begin
                  wdata_q <= {sd_in[7:0], held_byte};
                  stale_q <= !held_valid;
                  st      <= S_REQ;
                end else begin
                  st <= S_DONE;
                end
              end else begin
                st <= S_REQ;
              end
            end
          endcase
        end
        S_REQ: if (reg_req_ready) st <= cur_wr ? S_DONE : S_RSP;
        S_RSP: if (reg_rsp_valid) begin
          rdata_q <= lane_word;
          st      <= S_DONE;
        end
        S_DONE: if (ior_n && iow_n) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign chrdy_low     = (st == S_REQ) || (st == S_RSP);
  assign iocs16_low    = cur_wide && (st != S_IDLE);
  assign sd_oe_lo      = (st == S_DONE) && !cur_wr;
  assign sd_oe_hi      = (st == S_DONE) && !cur_wr && cur_wide;
  assign sd_out        = rdata_q;
  assign ctrl_reset    = rst_q;
  assign reg_req_valid = (st == S_REQ);
  assign reg_req_write = cur_wr;
  assign reg_req_idx   = cur_idx;
  assign reg_wdata     = wdata_q;
  assign reg_be        = (cur_wr || cur_wide) ? 2'b11 : (cur_odd ? 2'b10 : 2'b01);
  assign stale_odd     = (st == S_REQ) && cur_wr && stale_q;

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req_valid && !reg_req_ready) |=>
      (reg_req_valid && $stable(reg_wdata) && $stable(reg_req_idx) && $stable(reg_be)))
    else $error("request changed before acceptance");

  p_ready_when_driving_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sd_oe_lo |-> !chrdy_low)
    else $error("data driven while waiting");

  p_strobe_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sd_oe_lo) |-> $past(ior_n))
    else $error("read data dropped while strobe active");

  p_cs16_reg_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    iocs16_low |-> (cur_kind == K_REG))
    else $error("16-bit indication outside register cycle");

  p_hi_lane_wide_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sd_oe_hi |-> iocs16_low)
    else $error("high lane driven in 8-bit cycle");

  p_reset_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_reset |=> !ctrl_reset)
    else $error("reset pulse longer than one cycle");
endmodule

// File: tb/isa_reg_bridge_tb_top.sv
module isa_reg_bridge_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide_en = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic        aen = 1'b1;
  logic        ior_n = 1'b1;
  logic        iow_n = 1'b1;
  logic [15:0] sd_in = '0;
  logic [15:0] sd_out;
  logic        sd_oe_lo, sd_oe_hi, chrdy_low, iocs16_low;
  logic [127:0] sa_init;
  logic        ctrl_reset, stale_odd;
  logic        reg_req_valid, reg_req_write;
  logic        reg_req_ready = 1'b0;
  logic [1:0]  reg_req_idx;
  logic [1:0]  reg_be;
  logic [15:0] reg_wdata;
  logic        reg_rsp_valid = 1'b0;
  logic [15:0] reg_rdata = '0;

  int n_tests = 0;
  int n_fail  = 0;

  // Register-side model state
  logic [15:0] mregs [3];
  int  lat = 1;
  int  req_cnt = 0, write_cnt = 0;
  logic [15:0] last_wdata;
  logic [1:0]  last_be, last_idx;
  logic        last_stale;

  always #(CLK_PERIOD/2) clk = ~clk;

  isa_reg_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .wide_en(wide_en), .bus_addr(bus_addr),
    .aen(aen), .ior_n(ior_n), .iow_n(iow_n), .sd_in(sd_in), .sd_out(sd_out),
    .sd_oe_lo(sd_oe_lo), .sd_oe_hi(sd_oe_hi), .chrdy_low(chrdy_low),
    .iocs16_low(iocs16_low), .sa_init(sa_init), .ctrl_reset(ctrl_reset),
    .stale_odd(stale_odd), .reg_req_valid(reg_req_valid),
    .reg_req_ready(reg_req_ready), .reg_req_write(reg_req_write),
    .reg_req_idx(reg_req_idx), .reg_be(reg_be), .reg_wdata(reg_wdata),
    .reg_rsp_valid(reg_rsp_valid), .reg_rdata(reg_rdata)
  );

  function automatic logic [7:0] sa_byte(int k);
    return 8'(8'h51 + k * 7);
  endfunction

  task automatic chk(string req, bit ok, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Behavioural register file answering the request channel
  initial begin
    int wcnt = 0;
    bit pend = 0;
    bit waiting = 0;
    logic [15:0] pdata = '0;
    logic [15:0] w_prev = '0;
    logic [1:0]  i_prev = '0;
    for (int k = 0; k < 3; k++) mregs[k] = 16'h0000;
    forever begin
      @(negedge clk);
      reg_req_ready = 1'b0;
      reg_rsp_valid = 1'b0;
      if (waiting) begin
        // R11: an unaccepted request must still be present and unchanged
        chk("R11 request held", reg_req_valid && reg_wdata == w_prev && reg_req_idx == i_prev,
            int'(reg_req_valid), 1);
        waiting = 0;
      end
      if (pend) begin
        reg_rsp_valid = 1'b1;
        reg_rdata = pdata;
        pend = 0;
      end else if (reg_req_valid) begin
        if (wcnt >= lat) begin
          reg_req_ready = 1'b1;
          wcnt = 0;
          req_cnt++;
          if (reg_req_write) begin
            write_cnt++;
            last_wdata = reg_wdata;
            last_be    = reg_be;
            last_idx   = reg_req_idx;
            last_stale = stale_odd;
            if (reg_be[0]) mregs[reg_req_idx][7:0]  = reg_wdata[7:0];
            if (reg_be[1]) mregs[reg_req_idx][15:8] = reg_wdata[15:8];
          end else begin
            pend = 1;
            pdata = mregs[reg_req_idx];
          end
        end else begin
          wcnt++;
          waiting = 1;
          w_prev = reg_wdata;
          i_prev = reg_req_idx;
        end
      end
    end
  end

  logic [15:0] c_rd;
  logic        c_oe_lo, c_oe_hi, c_cs16, c_post_oe;
  int          c_rst, c_wait, c_hold_bad;

  task automatic io_cyc(input logic a_en, input logic wr, input logic [9:0] a,
                        input logic [15:0] d, input int hold);
    int guard = 0;
    @(negedge clk);
    bus_addr = a; aen = a_en; sd_in = d;
    if (wr) iow_n = 1'b0; else ior_n = 1'b0;
    c_cs16 = 0; c_rst = 0; c_wait = 0; c_hold_bad = 0;
    @(negedge clk);
    c_cs16 |= iocs16_low;
    c_rst  += int'(ctrl_reset);
    if (chrdy_low) c_wait++;
    while (chrdy_low && guard < 200) begin
      @(negedge clk);
      c_cs16 |= iocs16_low;
      c_rst  += int'(ctrl_reset);
      if (chrdy_low) c_wait++;
      guard++;
    end
    c_rd = sd_out; c_oe_lo = sd_oe_lo; c_oe_hi = sd_oe_hi;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      c_rst += int'(ctrl_reset);
      if (sd_oe_lo != c_oe_lo || sd_out != c_rd) c_hold_bad++;
    end
    ior_n = 1'b1; iow_n = 1'b1; aen = 1'b1;
    @(negedge clk);
    c_post_oe = sd_oe_lo;
    c_rst += int'(ctrl_reset);
    @(negedge clk);
  endtask

  initial begin
    int rc, wc;
    for (int k = 0; k < 16; k++) sa_init[8*k +: 8] = sa_byte(k);
    repeat (3) @(negedge clk);
    chk("R2 reset chrdy", !chrdy_low, int'(chrdy_low), 0);
    chk("R1 reset no request", !reg_req_valid && !sd_oe_lo, int'(reg_req_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: unqualified commands
    rc = req_cnt;
    io_cyc(1'b1, 1'b0, 10'h310, 16'h0, 0);
    chk("R1 aen high ignored", !c_oe_lo && req_cnt == rc, int'(c_oe_lo), 0);
    io_cyc(1'b0, 1'b0, 10'h340, 16'h0, 0);
    chk("R1 outside window ignored", !c_oe_lo && req_cnt == rc, int'(c_oe_lo), 0);

    // R4: station-address reads and write protection
    for (int k = 0; k < 16; k++) begin
      io_cyc(1'b0, 1'b0, 10'h300 + 10'(k), 16'h0, 0);
      chk("R4 station byte", c_oe_lo && c_rd[7:0] == sa_byte(k), int'(c_rd), int'(sa_byte(k)));
    end
    io_cyc(1'b0, 1'b1, 10'h303, 16'h00FF, 0);
    io_cyc(1'b0, 1'b0, 10'h303, 16'h0, 0);
    chk("R4 write protected", c_rd[7:0] == sa_byte(3) && req_cnt == rc, int'(c_rd), int'(sa_byte(3)));

    // R6: even then odd write
    wc = write_cnt;
    io_cyc(1'b0, 1'b1, 10'h310, 16'h0034, 0);
    chk("R6 even write held", write_cnt == wc, write_cnt, wc);
    io_cyc(1'b0, 1'b1, 10'h311, 16'h0012, 0);
    chk("R6 merged write count", write_cnt == wc + 1, write_cnt, wc + 1);
    chk("R6 merged data", last_wdata == 16'h1234 && last_idx == 2'd0, int'(last_wdata), 'h1234);
    chk("R6 merged lanes", last_be == 2'b11, int'(last_be), 3);
    chk("R7 fresh pair not stale", !last_stale, int'(last_stale), 0);

    // R5 / R2: byte reads with a slow register side
    lat = 3;
    io_cyc(1'b0, 1'b0, 10'h310, 16'h0, 0);
    chk("R5 even byte read", c_rd == 16'h0034 && !c_oe_hi, int'(c_rd), 'h34);
    chk("R2 stretched while busy", c_wait >= 4, c_wait, 4);
    io_cyc(1'b0, 1'b0, 10'h311, 16'h0, 0);
    chk("R5 odd byte moved down", c_rd == 16'h0012 && !c_oe_hi, int'(c_rd), 'h12);
    chk("R11 read data after response", c_oe_lo, int'(c_oe_lo), 1);
    lat = 1;

    // R7: odd write without even
    io_cyc(1'b0, 1'b1, 10'h313, 16'h00AB, 0);
    chk("R7 stale flagged", last_stale, int'(last_stale), 1);
    chk("R7 stale byte used", last_wdata == 16'hAB34 && last_idx == 2'd1, int'(last_wdata), 'hAB34);

    // R3: cycle held open
    io_cyc(1'b0, 1'b0, 10'h312, 16'h0, 5);
    chk("R3 data held", c_hold_bad == 0 && c_rd == 16'h0034, c_hold_bad, 0);
    chk("R3 release ends drive", !c_post_oe, int'(c_post_oe), 0);

    // R8: 16-bit cycles
    wide_en = 1'b1;
    wc = write_cnt;
    io_cyc(1'b0, 1'b1, 10'h314, 16'hBEEF, 0);
    chk("R8 wide write", write_cnt == wc + 1 && last_wdata == 16'hBEEF && last_idx == 2'd2,
        int'(last_wdata), 'hBEEF);
    chk("R8 wide write cs16", c_cs16, int'(c_cs16), 1);
    io_cyc(1'b0, 1'b0, 10'h314, 16'h0, 0);
    chk("R8 wide read", c_rd == 16'hBEEF && c_oe_hi && c_cs16, int'(c_rd), 'hBEEF);

    // R9 / R10
    io_cyc(1'b0, 1'b0, 10'h305, 16'h0, 0);
    chk("R9 no cs16 on station read", !c_cs16 && c_rd[7:0] == sa_byte(5), int'(c_cs16), 0);
    rc = req_cnt;
    io_cyc(1'b0, 1'b0, 10'h318, 16'h0, 0);
    chk("R9 no cs16 on reset read", !c_cs16, int'(c_cs16), 0);
    chk("R10 reset read pulses once", c_rst == 1 && req_cnt == rc, c_rst, 1);
    wide_en = 1'b0;
    io_cyc(1'b0, 1'b1, 10'h318, 16'h0, 0);
    chk("R10 reset write no pulse", c_rst == 0, c_rst, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule